// File: doc/BRIEF.md
# Strided Burst Memory Engine

This block is a word-addressed memory front end with its own synchronous single-port RAM. Commands arrive on a valid/ready command channel that carries a two-bit operation code and an address. Write data, a stride and a count each arrive on their own valid/ready channel. Read results and write acknowledgments leave in order on one valid/ready response stream.

There are four operations: a single read, a single write, a burst read and a burst write. A burst walks memory from the start address in steps of an unsigned stride. It makes `count` accesses, and the address wraps modulo the RAM depth. A burst read sends one word per step. A burst write takes one data word per step from the paced data channel and acknowledges each store with a zero word. While a burst runs, the command, stride and count channels are held off.

The controller is a three-state machine:
- **IDLE** accepts commands. It moves to **BURST_RD** when a burst read is accepted with a nonzero count. It moves to **BURST_WR** when a burst write is accepted with a nonzero count. A zero-count burst is consumed and the machine stays in IDLE.
- **BURST_RD** and **BURST_WR** return to IDLE on the step that uses the last count.

Top module: `stride_mem_engine`

## Requirements
- R1: After reset, `rsp_valid` is low, the machine is in IDLE, and a read command (`cmd_op`=0) is accepted (`cmd_ready` high) as long as the response slot is free.
- R2: Operation codes are 0 read, 1 write, 2 burst read and 3 burst write. A single read is accepted only when the response slot is free or is being emptied in the same cycle. The stored word appears on `rsp_data` with `rsp_valid` high in the cycle after acceptance.
- R3: A single write is accepted only when `cmd_valid` and `wdata_valid` are both high. The command and the data word are taken in the same cycle, and a response word of 0 follows one cycle later.
- R4: A burst command is accepted only when the command, stride and count channels are all valid. All three are taken in the same cycle.
- R5: A burst read with start A, stride S and count N sends N words, taken from addresses A, A+S, A+2S and so on, in that order. One word is sent per cycle in which the response slot is free.
- R6: A burst write takes one data word per step, and only in a cycle where the response slot is free. It stores the k-th word at A+k·S and sends a 0 acknowledgment for each store.
- R7: While a burst is active, `cmd_ready`, `stride_ready` and `count_ready` stay low.
- R8: A read of an address that has not been written since reset returns 0.
- R9: A burst with count 0 makes no memory access and no response, and the machine stays in IDLE.
- R10: Burst addresses wrap modulo the RAM depth (2^AW). The stride is unsigned.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.
- R12: `wdata_ready` is low except in two cases: during single-write acceptance in IDLE, and in BURST_WR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle if valid |
| cmd_op | input | 2 | 0 read, 1 write, 2 burst read, 3 burst write |
| cmd_addr | input | AW | Address or burst start address |
| wdata_valid | input | 1 | Write data present |
| wdata_ready | output | 1 | Write data taken this cycle if valid |
| wdata | input | DW | Write data word |
| stride_valid | input | 1 | Stride present |
| stride_ready | output | 1 | Stride taken this cycle if valid |
| stride | input | AW | Unsigned address increment per burst step |
| count_valid | input | 1 | Count present |
| count_ready | output | 1 | Count taken this cycle if valid |
| count | input | CW | Number of burst steps |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | DW | Read word, or 0 for a write acknowledgment |

## Verification
The assertions check the following on every cycle:
- the ready signals stay closed in the burst states;
- every accepted write or burst command has its companion channels taken in the same cycle;
- each burst step adds the stride and removes one count;
- the response is held steady under backpressure.

The bench scenarios are needed for the things a property cannot show: the word order of a burst, address wrap across the RAM end, zero reads from unwritten words, and zero-count bursts that leave no trace. A behavioural memory model and an ordered queue of expected responses check these.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_READ_MANY  = 2'd2,
        OP_WRITE_MANY = 2'd3
    } smem_op_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_BURST_RD = 2'd1,
        S_BURST_WR = 2'd2
    } smem_state_e;

endpackage

// File: rtl/smem_ram.sv
module smem_ram #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] written_q;
    logic [DW-1:0]    rdata_q;

    // storage array carries no reset
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    // per-word written flags make unwritten words read as zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written_q <= '0;
            rdata_q   <= '0;
        end else begin
            if (we) begin
                written_q[addr] <= 1'b1;
            end
            if (re) begin
                rdata_q <= written_q[addr] ? mem_q[addr] : '0;
            end
        end
    end

    assign rdata = rdata_q;

    // R6
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));

endmodule

// File: rtl/smem_agen.sv
module smem_agen #(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] stride_in,
    input  logic [CW-1:0] count_in,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] stride_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            addr_q   <= start_addr;
            stride_q <= stride_in;
            cnt_q    <= count_in;
        end else if (step) begin
            addr_q <= addr_q + stride_q;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (cnt_q == CW'(1));

    // R10
    stride_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == AW'($past(addr_q) + $past(stride_q))));

    // R5
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9
    no_empty_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q != '0));

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
    import smem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       cmd_ready,
    input  logic       wdata_valid,
    output logic       wdata_ready,
    input  logic       stride_valid,
    output logic       stride_ready,
    input  logic       count_valid,
    output logic       count_ready,
    input  logic       count_zero,
    input  logic       rsp_ready,
    output logic       rsp_valid,
    output logic       rsp_is_rd,
    input  logic       agen_last,
    output logic       agen_load,
    output logic       agen_step,
    output logic       ram_re,
    output logic       ram_we,
    output logic       use_agen
);
    smem_state_e state_q, state_d;
    smem_op_e    op;
    logic        rsp_valid_q, rsp_is_rd_q;
    logic        out_free;
    logic        rsp_load, load_is_rd;
    logic        burst_take;

    assign op       = smem_op_e'(cmd_op);
    assign out_free = !rsp_valid_q || rsp_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (burst_take && !count_zero) begin
                    state_d = (op == OP_READ_MANY) ? S_BURST_RD : S_BURST_WR;
                end
            end
            S_BURST_RD, S_BURST_WR: begin
                if (agen_step && agen_last) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready    = 1'b0;
        wdata_ready  = 1'b0;
        stride_ready = 1'b0;
        count_ready  = 1'b0;
        ram_re       = 1'b0;
        ram_we       = 1'b0;
        use_agen     = 1'b0;
        rsp_load     = 1'b0;
        load_is_rd   = 1'b0;
        agen_load    = 1'b0;
        agen_step    = 1'b0;
        burst_take   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                unique case (op)
                    OP_READ: begin
                        cmd_ready = out_free;
                        if (cmd_valid && out_free) begin
                            ram_re     = 1'b1;
                            rsp_load   = 1'b1;
                            load_is_rd = 1'b1;
                        end
                    end
                    OP_WRITE: begin
                        cmd_ready   = wdata_valid && out_free;
                        wdata_ready = cmd_valid && out_free;
                        if (cmd_valid && wdata_valid && out_free) begin
                            ram_we   = 1'b1;
                            rsp_load = 1'b1;
                        end
                    end
                    OP_READ_MANY, OP_WRITE_MANY: begin
                        cmd_ready    = stride_valid && count_valid;
                        stride_ready = cmd_valid && count_valid;
                        count_ready  = cmd_valid && stride_valid;
                        burst_take   = cmd_valid && stride_valid && count_valid;
                        agen_load    = burst_take && !count_zero;
                    end
                    default: ;
                endcase
            end
            S_BURST_RD: begin
                if (out_free) begin
                    ram_re     = 1'b1;
                    use_agen   = 1'b1;
                    rsp_load   = 1'b1;
                    load_is_rd = 1'b1;
                    agen_step  = 1'b1;
                end
            end
            S_BURST_WR: begin
                wdata_ready = out_free;
                if (out_free && wdata_valid) begin
                    ram_we    = 1'b1;
                    use_agen  = 1'b1;
                    rsp_load  = 1'b1;
                    agen_step = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // response slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_is_rd_q <= 1'b0;
        end else if (rsp_load) begin
            rsp_valid_q <= 1'b1;
            rsp_is_rd_q <= load_is_rd;
        end else if (rsp_ready) begin
            rsp_valid_q <= 1'b0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_is_rd = rsp_is_rd_q;

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (!cmd_ready && !stride_ready && !count_ready));

    // R12
    wdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST_RD) |-> !wdata_ready);

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && burst_take && count_zero) |=> (state_q == S_IDLE));

endmodule

// File: rtl/stride_mem_engine.sv
module stride_mem_engine #(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          wdata_valid,
    output logic          wdata_ready,
    input  logic [DW-1:0] wdata,
    input  logic          stride_valid,
    output logic          stride_ready,
    input  logic [AW-1:0] stride,
    input  logic          count_valid,
    output logic          count_ready,
    input  logic [CW-1:0] count,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data
);
    logic          rsp_is_rd;
    logic          agen_last, agen_load, agen_step;
    logic          ram_re, ram_we, use_agen;
    logic [AW-1:0] agen_addr, ram_addr;
    logic [DW-1:0] ram_rdata;
    logic          count_zero;

    assign count_zero = (count == '0);
    assign ram_addr   = use_agen ? agen_addr : cmd_addr;
    assign rsp_data   = rsp_is_rd ? ram_rdata : '0;

    smem_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_ready    (cmd_ready),
        .wdata_valid  (wdata_valid),
        .wdata_ready  (wdata_ready),
        .stride_valid (stride_valid),
        .stride_ready (stride_ready),
        .count_valid  (count_valid),
        .count_ready  (count_ready),
        .count_zero   (count_zero),
        .rsp_ready    (rsp_ready),
        .rsp_valid    (rsp_valid),
        .rsp_is_rd    (rsp_is_rd),
        .agen_last    (agen_last),
        .agen_load    (agen_load),
        .agen_step    (agen_step),
        .ram_re       (ram_re),
        .ram_we       (ram_we),
        .use_agen     (use_agen)
    );

    smem_agen #(.AW(AW), .CW(CW)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (agen_load),
        .step       (agen_step),
        .start_addr (cmd_addr),
        .stride_in  (stride),
        .count_in   (count),
        .addr       (agen_addr),
        .last       (agen_last)
    );

    smem_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (wdata),
        .rdata (ram_rdata)
    );

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R3
    write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd1) |-> (wdata_valid && wdata_ready));

    // R4
    burst_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op[1]) |->
            (stride_valid && stride_ready && count_valid && count_ready));

endmodule

// File: tb/stride_mem_engine_bench.sv
module stride_mem_engine_bench;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          wdata_valid = 1'b0;
    logic          wdata_ready;
    logic [DW-1:0] wdata = '0;
    logic          stride_valid = 1'b0;
    logic          stride_ready;
    logic [AW-1:0] stride = '0;
    logic          count_valid = 1'b0;
    logic          count_ready;
    logic [CW-1:0] count = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [DW-1:0] rsp_data;

    stride_mem_engine #(.DW(DW), .AW(AW), .CW(CW)) u_stride_mem_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .stride_valid(stride_valid), .stride_ready(stride_ready), .stride(stride),
        .count_valid(count_valid), .count_ready(count_ready), .count(count),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    // 50 MHz
    always #10 clk = ~clk;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int dseq = 0;
    bit wgap = 1'b0;
    bit rr_mode = 1'b0;
    bit hold_stall = 1'b0;

    logic [DW-1:0] mem_m [DEPTH];
    bit            wr_m  [DEPTH];
    logic [DW-1:0] exp_q [$];
    int            exp_r [$];
    logic [DW-1:0] wq    [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] m_read(input int a);
        return wr_m[a % DEPTH] ? mem_m[a % DEPTH] : '0;
    endfunction

    // write-data feeder
    always begin
        @(negedge clk); #1;
        if (wq.size() > 0 && !(wgap && (cyc % 3 == 0))) begin
            wdata_valid = 1'b1;
            wdata       = wq[0];
        end else begin
            wdata_valid = 1'b0;
        end
    end

    // response-ready driver
    always begin
        @(negedge clk); #1;
        rsp_ready = hold_stall ? 1'b0 : (rr_mode ? (cyc % 4 != 1) : 1'b1);
    end

    // monitor: compares against the reference queue just before each edge
    always begin
        @(negedge clk); #9;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", rsp_data, 0);
            end else begin
                logic [DW-1:0] e;
                int r;
                e = exp_q.pop_front();
                r = exp_r.pop_front();
                chk(rsp_data === e, $sformatf("R%0d response word", r), rsp_data, e);
            end
        end
        if (rst_n && wdata_valid && wdata_ready && wq.size() > 0) begin
            void'(wq.pop_front());
        end
    end

    // issue one command; the model is updated at acceptance
    task automatic issue(input logic [1:0] op, input int a, input int s, input int n);
        int k;
        if (op == 2'd1) begin
            wq.push_back(32'hC0DE_0000 + dseq);
        end else if (op == 2'd3) begin
            for (int i = 0; i < n; i++) wq.push_back(32'hC0DE_0000 + dseq + i);
        end
        @(negedge clk); #1;
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_addr     = AW'(a);
        stride       = AW'(s);
        count        = CW'(n);
        stride_valid = op[1];
        count_valid  = op[1];
        forever begin
            #8;
            if (cmd_ready) break;
            @(negedge clk); #1;
        end
        case (op)
            2'd0: begin exp_q.push_back(m_read(a)); exp_r.push_back(2); end // R2
            2'd1: begin
                mem_m[a % DEPTH] = 32'hC0DE_0000 + dseq; wr_m[a % DEPTH] = 1'b1;
                dseq++;
                exp_q.push_back('0); exp_r.push_back(3); // R3
            end
            2'd2: begin
                for (int i = 0; i < n; i++) begin
                    k = (a + i * s) % DEPTH;
                    exp_q.push_back(m_read(k)); exp_r.push_back(5); // R5
                end
            end
            default: begin
                for (int i = 0; i < n; i++) begin
                    k = (a + i * s) % DEPTH;
                    mem_m[k] = 32'hC0DE_0000 + dseq + i; wr_m[k] = 1'b1;
                    exp_q.push_back('0); exp_r.push_back(6); // R6
                end
                dseq += n;
            end
        endcase
        @(posedge clk); #1;
        cmd_valid    = 1'b0;
        stride_valid = 1'b0;
        count_valid  = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_q.size() != 0 || wq.size() != 0) && t < 3000) begin
            @(posedge clk);
            t++;
        end
        chk(exp_q.size() == 0 && wq.size() == 0, "R5 stream drained", exp_q.size(), 0);
        repeat (2) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        for (int i = 0; i < DEPTH; i++) begin mem_m[i] = '0; wr_m[i] = 1'b0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #5;
        // R1 reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        chk(cmd_ready == 1'b1, "R1 read ready when idle", cmd_ready, 1);

        // R8 unwritten word reads as zero
        issue(2'd0, 77, 0, 0);
        #4;
        chk(rsp_valid == 1'b1 && rsp_data == '0, "R8 unwritten read", rsp_data, 0);
        drain();

        // R3 single write, then R2 read latency of one cycle
        issue(2'd1, 10, 0, 0);
        issue(2'd0, 10, 0, 0);
        #4;
        chk(rsp_valid == 1'b1 && rsp_data == m_read(10), "R2 read one cycle after accept",
            rsp_data, m_read(10));
        drain();

        // R12 write data is not taken while idle with a read op
        wq.push_back(32'hDEAD_BEEF);
        @(negedge clk); #1;
        cmd_op = 2'd0;
        #8;
        chk(wdata_ready == 1'b0, "R12 wdata held off when not writing", wdata_ready, 0);
        repeat (3) @(posedge clk);
        chk(wq.size() == 1, "R12 data word not consumed", wq.size(), 1);
        void'(wq.pop_front());

        // R6 / R5 burst write then burst read
        issue(2'd3, 40, 1, 5);
        issue(2'd2, 40, 1, 5);
        drain();

        // R4 burst waits for the count channel
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = AW'(40);
        stride_valid = 1'b1; stride = AW'(2); count = CW'(3); count_valid = 1'b0;
        #8;
        chk(cmd_ready == 1'b0 && stride_ready == 1'b0, "R4 held without count",
            {cmd_ready, stride_ready}, 0);
        @(negedge clk); #1;
        count_valid = 1'b1;
        #8;
        chk(cmd_ready && stride_ready && count_ready, "R4 all three taken together",
            {cmd_ready, stride_ready, count_ready}, 3'b111);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(m_read(40 + 2 * i)); exp_r.push_back(4);
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0; stride_valid = 1'b0; count_valid = 1'b0;
        drain();

        // R9 zero count burst
        issue(2'd2, 20, 1, 0);
        repeat (3) @(posedge clk);
        #5;
        chk(rsp_valid == 1'b0, "R9 zero count gives no response", rsp_valid, 0);
        issue(2'd3, 60, 1, 0);
        issue(2'd0, 60, 0, 0);
        drain();
        chk(wr_m[60] == 1'b0, "R9 zero-count write stored nothing", wr_m[60], 0);

        // R7 / R11 / R12 under backpressure during a burst read
        hold_stall = 1'b1;
        issue(2'd2, 40, 1, 5);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 2'd0; stride_valid = 1'b1; count_valid = 1'b1;
        #4;
        held = rsp_data;
        chk(rsp_valid == 1'b1, "R11 response pending under stall", rsp_valid, 1);
        chk(cmd_ready == 1'b0, "R7 cmd_ready low in burst", cmd_ready, 0);
        chk(stride_ready == 1'b0 && count_ready == 1'b0, "R7 stride/count held off",
            {stride_ready, count_ready}, 0);
        chk(wdata_ready == 1'b0, "R12 wdata_ready low in burst read", wdata_ready, 0);
        repeat (3) @(posedge clk);
        #5;
        chk(rsp_data == held && rsp_valid, "R11 data stable under stall", rsp_data, held);
        @(negedge clk); #1;
        cmd_valid = 1'b0; stride_valid = 1'b0; count_valid = 1'b0;
        hold_stall = 1'b0;
        drain();

        // R10 wrap past the top of memory
        issue(2'd3, 250, 3, 4);
        issue(2'd0, 0, 0, 0);
        issue(2'd0, 3, 0, 0);
        issue(2'd2, 250, 3, 4);
        drain();
        chk(m_read(3) == 32'hC0DE_0000 + dseq - 1, "R10 last wrapped word model",
            m_read(3), 32'hC0DE_0000 + dseq - 1);

        // R5 / R6 with paced data and a gapped response consumer
        wgap = 1'b1;
        rr_mode = 1'b1;
        issue(2'd3, 100, 200, 6);
        issue(2'd2, 100, 200, 6);
        issue(2'd1, 5, 0, 0);
        issue(2'd0, 5, 0, 0);
        issue(2'd2, 99, 1, 3);
        drain();
        wgap = 1'b0;
        rr_mode = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule